// File: doc/BRIEF.md
# Daisy-Chainable 24-Bit Serial Command Receiver

This block is the serial front end of a command-driven peripheral. A host frames each transfer with an active-low chip select, clocks 24-bit command words in most significant bit first, and the block presents the completed word to the command controller as a one-cycle strobe in the system clock domain once chip select returns high. All serial pins are brought into the system clock through two-flop synchronisers and their edges are detected there, so the whole block runs on a single clock.

The same 24-bit register that captures incoming bits also feeds the serial output. While a frame is in progress, whatever the register held before the frame leaves on the output line, one bit per serial clock. A device further along a chain therefore receives the older bits, and only the newest 24 bits stay here as this device's command. The controller can park a read response in that register between frames; the host collects it by sending any further frame, typically a no-operation word. The output is modelled as an open-drain line: an enable that is high only while selected, and a pull-low signal that is asserted for a zero bit.

Top module: `chain_spi_slave`

## Requirements
- R1: Serial data is taken on each rising serial clock edge while selected, first bit received becoming bit 23 of `cmd_word_o`; after a valid frame `cmd_word_o` equals the last 24 bits received, in received order.
- R2: When chip select rises after a frame of 24, 48, 72 or any other non-zero multiple of 24 serial clocks, `cmd_valid_o` is high for exactly one system clock, no later than 6 system clocks after the rise and only while the output is released.
- R3: A frame whose clock count is zero or not a multiple of 24 produces no pulse on `cmd_valid_o`, and `cmd_word_o` keeps its previous value.
- R4: During a frame the output line carries the register contents from before the frame, most significant bit first, followed by the bits received in this frame delayed by 24 clocks, so a downstream device sampling on the rising edge sees the older bits.
- R5: The first output bit is valid after chip select falls and before the first rising serial clock; each further bit is updated after a falling serial clock edge.
- R6: While deselected `spi_sdo_en_o` and `spi_sdo_pull_o` are both 0 (line released); while selected `spi_sdo_en_o` is 1 and `spi_sdo_pull_o` is 1 exactly when the current output bit is 0.
- R7: Until a high-to-low chip select transition has been seen after reset, serial clocks are ignored: they neither shift the register nor lead to a command pulse.
- R8: A pulse on `rsp_load_i` while deselected replaces the register with `rsp_word_i`, which is shifted out during the next frame; a pulse while selected has no effect.
- R9: After reset `cmd_valid_o` is 0, `cmd_word_o` and the shift register are all zeros, and the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_ni | input | 1 | Active-low chip select from the host |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_en_o | output | 1 | High while the device owns the output line |
| spi_sdo_pull_o | output | 1 | Drive the output line low (open-drain zero) |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_word_o | output | 24 | Last accepted command word |
| rsp_load_i | input | 1 | Load a response word into the shift register |
| rsp_word_i | input | 24 | Response word to shift out in the next frame |

## Verification
The bench sweeps the frame length over every count from 0 to 72 clocks with fresh data, so a design that counted modulo the wrong length, accepted an empty or partial frame, or kept the first instead of the last 24 bits would strobe at the wrong counts or present the wrong word. It records every output bit a downstream device would sample and compares it with the stream formed by the previous register contents followed by the new bits; an off-by-one in the output timing or a missing first bit on chip select fall shows up as a shifted stream. It also clocks with chip select held low from reset, loads a response between frames and another in the middle of a frame, which catches a design that arms without a falling edge or lets a late load corrupt bits in flight.

// File: rtl/cspi_pkg.sv
`timescale 1ns/1ps
package cspi_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } cspi_edge_t;

  function automatic int cnt_w(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cspi_sync.sv
`timescale 1ns/1ps
module cspi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cspi_edge.sv
`timescale 1ns/1ps
module cspi_edge
  import cspi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  output cspi_edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign edge_o.rise = lvl_i & ~prev_q;
  assign edge_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/cspi_shift_path.sv
`timescale 1ns/1ps
module cspi_shift_path
  import cspi_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         bit_clk_i,
  input  logic         sdi_i,
  input  logic         load_i,
  input  logic [W-1:0] load_word_i,
  output logic [W-1:0] word_o,
  output logic         msb_o,
  output logic         in_frame_o,
  output logic         whole_o
);
  localparam int             CW   = cnt_w(W);
  localparam logic [CW-1:0]  LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          full_q;
  logic          in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      if (start_i) begin
        in_frame_q <= 1'b1;
        cnt_q      <= '0;
        full_q     <= 1'b0;
      end else if (stop_i) begin
        in_frame_q <= 1'b0;
      end
      if (in_frame_q && bit_clk_i) begin
        sr_q <= {sr_q[W-2:0], sdi_i};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (load_i && !in_frame_q && !start_i) begin
        sr_q <= load_word_i;
      end
    end
  end

  assign word_o     = sr_q;
  assign msb_o      = sr_q[W-1];
  assign in_frame_o = in_frame_q;
  // at least one whole word and no partial remainder
  assign whole_o    = full_q && (cnt_q == '0);
endmodule

// File: rtl/cspi_sdo.sv
`timescale 1ns/1ps
module cspi_sdo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_fall_i,
  input  logic in_frame_i,
  input  logic msb_i,
  output logic en_o,
  output logic pull_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             bit_q <= 1'b1;
    else if (start_i || (bit_fall_i && in_frame_i)) bit_q <= msb_i;
  end

  assign en_o   = in_frame_i;
  assign pull_o = in_frame_i & ~bit_q;
endmodule

// File: rtl/chain_spi_slave.sv
`timescale 1ns/1ps
module chain_spi_slave
  import cspi_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_cs_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_sdi_i,
  output logic              spi_sdo_en_o,
  output logic              spi_sdo_pull_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o,
  input  logic              rsp_load_i,
  input  logic [WORD_W-1:0] rsp_word_i
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_s;
  logic            cs_n_s, sclk_s, sdi_s;
  cspi_edge_t      cs_e, sclk_e;
  logic [WORD_W-1:0] sr_word;
  logic            sr_msb, in_frame, whole;
  logic            valid_q;
  logic [WORD_W-1:0] cmd_q;

  cspi_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_cs_ni, spi_sclk_i, spi_sdi_i}),
    .q_o    (pin_s)
  );

  assign {cs_n_s, sclk_s, sdi_s} = pin_s;

  cspi_edge u_cs_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (cs_n_s),
    .edge_o (cs_e)
  );

  cspi_edge u_sclk_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sclk_s),
    .edge_o (sclk_e)
  );

  cspi_shift_path #(.W(WORD_W)) u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cs_e.fall),
    .stop_i      (cs_e.rise),
    .bit_clk_i   (sclk_e.rise),
    .sdi_i       (sdi_s),
    .load_i      (rsp_load_i),
    .load_word_i (rsp_word_i),
    .word_o      (sr_word),
    .msb_o       (sr_msb),
    .in_frame_o  (in_frame),
    .whole_o     (whole)
  );

  cspi_sdo u_sdo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cs_e.fall),
    .bit_fall_i (sclk_e.fall),
    .in_frame_i (in_frame),
    .msb_i      (sr_msb),
    .en_o       (spi_sdo_en_o),
    .pull_o     (spi_sdo_pull_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (cs_e.rise && in_frame && whole) begin
        valid_q <= 1'b1;
        cmd_q   <= sr_word;
      end
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_word_o  = cmd_q;
endmodule

// File: rtl/chain_spi_slave_chk.sv
`timescale 1ns/1ps
module chain_spi_slave_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_sdo_en_o,
  input logic              spi_sdo_pull_o,
  input logic              cmd_valid_o,
  input logic [WORD_W-1:0] cmd_word_o
);
  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_strobe_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !spi_sdo_en_o);

  assert_word_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> $stable(cmd_word_o));

  assert_release_no_pull_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_sdo_en_o |-> !spi_sdo_pull_o);
endmodule

bind chain_spi_slave chain_spi_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .spi_sdo_en_o   (spi_sdo_en_o),
  .spi_sdo_pull_o (spi_sdo_pull_o),
  .cmd_valid_o    (cmd_valid_o),
  .cmd_word_o     (cmd_word_o)
);

// File: tb/chain_spi_slave_tb_top.sv
`timescale 1ns/1ps
module chain_spi_slave_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        rsp_load = 1'b0;
  logic [23:0] rsp_word = '0;
  logic        sdo_en, sdo_pull, cmd_valid;
  logic [23:0] cmd_word;

  int vecs = 0;
  int errs = 0;
  int pulses = 0;
  bit done = 0;
  logic [23:0] m_sr = '0;
  logic [23:0] m_cmd = '0;

  always #2.5 clk = ~clk;

  chain_spi_slave dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .spi_cs_ni      (cs_n),
    .spi_sclk_i     (sclk),
    .spi_sdi_i      (sdi),
    .spi_sdo_en_o   (sdo_en),
    .spi_sdo_pull_o (sdo_pull),
    .cmd_valid_o    (cmd_valid),
    .cmd_word_o     (cmd_word),
    .rsp_load_i     (rsp_load),
    .rsp_word_i     (rsp_word)
  );

  always @(negedge clk) if (cmd_valid) pulses++;

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input int n, input logic [95:0] bits, input int load_at);
    logic [95:0] seen = '0;
    logic [95:0] expv = '0;
    int en_bad = 0;
    int p0;
    bit ok;
    p0 = pulses;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      if (i == load_at) begin
        rsp_word = 24'hA5C3F0;
        rsp_load = 1'b1;
        @(negedge clk);
        rsp_load = 1'b0;
        repeat (HALF - 1) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (!sdo_en) en_bad++;
      seen[n-1-i] = ~sdo_pull;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    // model: each clock shows the current MSB, then shifts the new bit in
    for (int k = 0; k < n; k++) begin
      expv[n-1-k] = m_sr[23];
      m_sr = {m_sr[22:0], bits[n-1-k]};
    end
    ok = (n > 0) && (n % 24 == 0);
    if (ok) m_cmd = m_sr;
    if (n > 0) begin
      check("R4 R5 sdo stream", seen, expv);
      check("R6 enable while selected", 96'(en_bad), 96'd0);
    end
    check(ok ? "R2 strobe count" : "R3 no strobe", 96'(pulses - p0), ok ? 96'd1 : 96'd0);
    check("R1 command word", 96'(cmd_word), 96'(m_cmd));
    check("R6 released", {94'd0, sdo_en, sdo_pull}, 96'd0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // chip select held low through reset: no falling edge yet
    cs_n = 1'b0;
    sdi  = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9 reset outputs", {70'd0, sdo_en, sdo_pull, cmd_valid, cmd_word}, 96'd0);
    for (int i = 0; i < 24; i++) begin
      sclk = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (10) @(negedge clk); #1;
    check("R7 no strobe before arming", 96'(pulses), 96'd0);
    check("R7 word untouched", 96'(cmd_word), 96'd0);
    // previous contents must still be zero (R7, R9)
    frame(24, 96'hC3_5A_81, -1);

    // response loaded while deselected (R8)
    @(negedge clk);
    rsp_word = 24'h9E_1B_6D;
    rsp_load = 1'b1;
    @(negedge clk);
    rsp_load = 1'b0;
    m_sr = 24'h9E_1B_6D;
    frame(24, 96'h0, -1);

    // load in the middle of a frame has no effect (R8)
    frame(48, {48'd0, 48'h0F0F_F0F0_1234}, 30);

    // sweep of all frame lengths up to three words
    for (int n = 0; n <= 72; n++) begin
      logic [95:0] b;
      b = {$urandom, $urandom, $urandom};
      frame(n, b, -1);
    end

    // all ones / all zeros, two words
    frame(48, {48'd0, 48'hFFFF_FFFF_FFFF}, -1);
    frame(48, 96'd0, -1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule